// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. It works with an external comparator and capacitive DAC. For each conversion it first runs a sample phase with the sample/hold strobe low and the DAC code parked at midscale. It then raises the strobe and runs one bit trial per clock, from the most significant bit down. A trial sets the bit under test on top of the bits already decided. One clock later it reads the comparator, which is high when the analog input is at or above the code, and keeps the bit only when the comparator is high. After the last trial the block registers the code as the result and pulses a completion flag.

Enabling the block raises an amplifier-enable output one clock later. A settle-assist strobe is high for the first two clocks of that enable. The same enable edge starts a warm-up conversion. That conversion runs the full sequence but is thrown away: it neither updates the result nor raises the completion flag. Dropping the enable aborts any conversion in progress, and the next enable runs the warm-up conversion again.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While reset is high, and on the first clock after it, the outputs read as follows: DAC code 0x200, hold low, busy low, done low, result 0, amplifier enable low, settle strobe low.
- R2: Whenever hold is low, the DAC code equals the midscale value 0x200.
- R3: The first clock edge that sees `en` high after reset, or after `en` was low, starts a warm-up conversion (busy high from the next clock). That conversion never raises `done_o` and leaves `result_o` unchanged.
- R4: `amp_en_o` follows `en` one clock later. `settle_o` is high for exactly the first two clocks in which `amp_en_o` is high, and it is never high while `amp_en_o` is low.
- R5: A start request is accepted when it is high at an edge where the block is enabled, idle and has no warm-up conversion pending. Hold is low for the 4 clocks after the accepting edge and rises at the 4th edge after it. Done is high in the clock after the 14th edge after it, when busy and hold are low again.
- R6: The trials run from bit 9 down to bit 0. The code presented for the trial of bit k holds the already decided bits above k, with bit k set to 1 and the bits below k at 0.
- R7: A bit is kept when the comparator is high (input at or above the code) and cleared when it is low. With a comparator that reports input >= code, the result equals the input code for every input from 0 to 1023.
- R8: A start request while busy is ignored. It neither restarts the running conversion nor queues a second one.
- R9: `done_o` is high for one clock only, and only after a non-warm-up conversion. It is never high while busy.
- R10: Driving `en` low aborts any conversion: on the next clock busy and hold are low and the DAC code is 0x200. A start request while `en` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable |
| start | input | 1 | Conversion request, sampled at the clock edge |
| cmp_i | input | 1 | Comparator output, high when the input is at or above the DAC code |
| dac_o | output | 10 | DAC code driven to the capacitive array |
| hold_o | output | 1 | Sample/hold strobe, low while sampling |
| amp_en_o | output | 1 | Amplifier enable |
| settle_o | output | 1 | Settle-assist strobe after the amplifier is enabled |
| busy_o | output | 1 | Conversion (warm-up or normal) in progress |
| result_o | output | 10 | Result of the last normal conversion |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The assertions check rules that must hold on every cycle: the midscale park whenever hold is low, the settle strobe's length and its tie to the amplifier enable, the single-clock done pulse with busy low, hold implying busy, and the abort on enable low. Other behaviours need whole scenarios and show only in the bench. These are the result for every one of the 1024 input codes, the exact code presented in each bit trial, the warm-up conversion that stays silent, the start ignored while busy or disabled, and the cycle on which hold and done change.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_TRIAL  = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_amp_ctl.sv
// Amplifier enable and the settle-assist strobe that follows its rising edge.
module sar_amp_ctl #(
  parameter int SETTLE_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic amp_en_o,
  output logic settle_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC) + 1;

  logic [CNT_W-1:0] left_q;
  logic             rise;

  assign rise = en & ~amp_en_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_en_o <= 1'b0;
      settle_o <= 1'b0;
      left_q   <= '0;
    end else begin
      amp_en_o <= en;
      if (!en) begin
        settle_o <= 1'b0;
        left_q   <= '0;
      end else if (rise) begin
        settle_o <= 1'b1;
        left_q   <= CNT_W'(SETTLE_CYC - 1);
      end else if (settle_o) begin
        if (left_q == '0) begin
          settle_o <= 1'b0;
        end else begin
          left_q <= left_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sar_seq.sv
// Phase sequencer: idle, sample window, bit trials; warm-up tracking.
module sar_seq
  import sar_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int SAMPLE_CYC = 4,
  localparam int IDX_W     = (RES_W > 1) ? $clog2(RES_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  output logic             step_o,
  output logic             last_o,
  output logic             dummy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             hold_o,
  output logic             busy_o
);
  localparam int CNT_W = $clog2(SAMPLE_CYC) + 1;

  sar_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             pend_q;
  logic             cur_dummy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      idx_q       <= '0;
      hold_o      <= 1'b0;
      pend_q      <= 1'b1;
      cur_dummy_q <= 1'b0;
    end else if (!en) begin
      state_q <= ST_IDLE;
      hold_o  <= 1'b0;
      pend_q  <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (pend_q || start) begin
            state_q     <= ST_SAMPLE;
            cnt_q       <= '0;
            cur_dummy_q <= pend_q;
            pend_q      <= 1'b0;
          end
        end
        ST_SAMPLE: begin
          if (cnt_q == CNT_W'(SAMPLE_CYC - 1)) begin
            state_q <= ST_TRIAL;
            hold_o  <= 1'b1;
            idx_q   <= IDX_W'(RES_W - 1);
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_TRIAL: begin
          if (idx_q == '0) begin
            state_q <= ST_IDLE;
            hold_o  <= 1'b0;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign step_o  = en && (state_q == ST_TRIAL);
  assign last_o  = (idx_q == '0);
  assign idx_o   = idx_q;
  assign dummy_o = cur_dummy_q;
  assign busy_o  = (state_q != ST_IDLE);
endmodule

// File: rtl/sar_datapath.sv
// The DAC code register doubles as the approximation register.
module sar_datapath #(
  parameter int RES_W  = 10,
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_i,
  input  logic             step_i,
  input  logic             last_i,
  input  logic             dummy_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [RES_W-1:0] dac_o,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);
  localparam logic [RES_W-1:0] MID_CODE = RES_W'(1) << (RES_W - 1);

  logic [RES_W-1:0] trial_mask;
  logic [RES_W-1:0] next_mask;
  logic [RES_W-1:0] decided;

  assign trial_mask = RES_W'(1) << idx_i;
  assign next_mask  = trial_mask >> 1;
  assign decided    = cmp_i ? dac_o : (dac_o & ~trial_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_o    <= MID_CODE;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (step_i && last_i) begin
        dac_o <= MID_CODE;
        if (!dummy_i) begin
          result_o <= decided;
          done_o   <= 1'b1;
        end
      end else if (step_i) begin
        dac_o <= decided | next_mask;
      end else begin
        dac_o <= MID_CODE;
      end
    end
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int RES_W      = 10,
  parameter int SAMPLE_CYC = 4,
  parameter int SETTLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_o,
  output logic             hold_o,
  output logic             amp_en_o,
  output logic             settle_o,
  output logic             busy_o,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;

  logic             step;
  logic             last;
  logic             dummy;
  logic [IDX_W-1:0] idx;

  sar_amp_ctl #(.SETTLE_CYC(SETTLE_CYC)) amp_i (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .amp_en_o (amp_en_o),
    .settle_o (settle_o)
  );

  sar_seq #(.RES_W(RES_W), .SAMPLE_CYC(SAMPLE_CYC)) seq_i (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .start   (start),
    .step_o  (step),
    .last_o  (last),
    .dummy_o (dummy),
    .idx_o   (idx),
    .hold_o  (hold_o),
    .busy_o  (busy_o)
  );

  sar_datapath #(.RES_W(RES_W)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .cmp_i    (cmp_i),
    .step_i   (step),
    .last_i   (last),
    .dummy_i  (dummy),
    .idx_i    (idx),
    .dac_o    (dac_o),
    .result_o (result_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int RES_W      = 10,
  parameter int SETTLE_CYC = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [RES_W-1:0] dac_o,
  input logic             hold_o,
  input logic             amp_en_o,
  input logic             settle_o,
  input logic             busy_o,
  input logic [RES_W-1:0] result_o,
  input logic             done_o
);
  localparam logic [RES_W-1:0] MID_CODE = RES_W'(1) << (RES_W - 1);

  int unsigned settle_run;

  always_ff @(posedge clk) begin
    if (rst) settle_run <= 0;
    else     settle_run <= settle_o ? settle_run + 1 : 0;
  end

  a_r2_mid_when_sampling: assert property (@(posedge clk) disable iff (rst)
    !hold_o |-> dac_o == MID_CODE);

  a_r4_settle_needs_amp: assert property (@(posedge clk) disable iff (rst)
    settle_o |-> amp_en_o);

  a_r4_settle_on_amp_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(amp_en_o) |-> settle_o);

  a_r4_settle_length: assert property (@(posedge clk) disable iff (rst)
    settle_o |-> settle_run < SETTLE_CYC);

  a_r5_hold_inside_busy: assert property (@(posedge clk) disable iff (rst)
    hold_o |-> busy_o);

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r9_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  a_r7_result_moves_with_done: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));

  a_r10_abort_on_disable: assert property (@(posedge clk) disable iff (rst)
    !en |=> !busy_o && !hold_o);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(
  .RES_W      (RES_W),
  .SETTLE_CYC (SETTLE_CYC)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .dac_o    (dac_o),
  .hold_o   (hold_o),
  .amp_en_o (amp_en_o),
  .settle_o (settle_o),
  .busy_o   (busy_o),
  .result_o (result_o),
  .done_o   (done_o)
);

// File: tb/sar_conv_ctrl_tb_top.sv
`timescale 1ns/1ps
module sar_conv_ctrl_tb_top;
  localparam int N   = 10;
  localparam int S   = 4;
  localparam int MID = 512;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] ain = '0;
  logic         cmp;
  logic [N-1:0] dac;
  logic         hold, amp_en, settle, busy, done;
  logic [N-1:0] result;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign cmp = (ain >= dac);

  sar_conv_ctrl #(.RES_W(N), .SAMPLE_CYC(S), .SETTLE_CYC(2)) dut_i (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .start    (start),
    .cmp_i    (cmp),
    .dac_o    (dac),
    .hold_o   (hold),
    .amp_en_o (amp_en),
    .settle_o (settle),
    .busy_o   (busy),
    .result_o (result),
    .done_o   (done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One accepted conversion; checks hold timing, trial codes and result.
  task automatic convert(input int v, input bit trace);
    ain = N'(v);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 1; i <= S + N; i++) begin
      @(negedge clk);
      if (trace) begin
        if (i < S) begin
          chk("R5 hold low in sample", int'(hold), 0);
          chk("R2 dac parked", int'(dac), MID);
        end else if (i < S + N) begin
          int k;
          k = N - 1 - (i - S);
          chk("R5 hold high in trials", int'(hold), 1);
          chk("R6 trial code", int'(dac), ((v >> (k + 1)) << (k + 1)) | (1 << k));
        end
      end
      if (i < S + N) chk("R9 no early done", int'(done), 0);
    end
    chk("R7 result", int'(result), v);
    chk("R5 done at end", int'(done), 1);
    if (trace) begin
      chk("R5 busy low at end", int'(busy), 0);
      chk("R2 dac back to mid", int'(dac), MID);
    end
    @(negedge clk);
    chk("R9 done one clock", int'(done), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int dones;
    repeat (3) @(negedge clk);
    chk("R1 dac", int'(dac), MID);
    chk("R1 hold", int'(hold), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 result", int'(result), 0);
    chk("R1 amp", int'(amp_en), 0);
    chk("R1 settle", int'(settle), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", int'(busy), 0);

    // R10: start while disabled is ignored
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk);
    chk("R10 start ignored when disabled", int'(busy), 0);

    // R3/R4: enable starts a silent warm-up conversion and the settle strobe
    ain = 10'h155;
    en = 1'b1;
    @(negedge clk);
    chk("R4 amp follows en", int'(amp_en), 1);
    chk("R4 settle first clock", int'(settle), 1);
    chk("R3 warm-up busy", int'(busy), 1);
    @(negedge clk);
    chk("R4 settle second clock", int'(settle), 1);
    @(negedge clk);
    chk("R4 settle third clock low", int'(settle), 0);
    dones = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk("R3 warm-up raises no done", dones, 0);
    chk("R3 warm-up leaves result", int'(result), 0);
    chk("R3 warm-up finished", int'(busy), 0);

    // R5/R6/R7: traced conversions on distinct patterns
    convert(0, 1'b1);
    convert(1023, 1'b1);
    convert(512, 1'b1);
    convert(511, 1'b1);
    convert(10'h2AA, 1'b1);
    convert(10'h155, 1'b1);

    // R7: full sweep of every input code
    for (int v = 0; v < 1024; v++) convert(v, 1'b0);

    // R8: start while busy is ignored
    ain = 10'd300;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (S + N - 2) @(negedge clk);
    chk("R8 done not delayed by second start", int'(done), 1);
    chk("R8 result", int'(result), 300);
    @(negedge clk);
    chk("R8 no queued conversion", int'(busy), 0);
    @(negedge clk);
    chk("R8 still idle", int'(busy), 0);

    // R10: abort mid-conversion, then re-enable reruns warm-up
    ain = 10'd77;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (S + 3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R10 abort busy", int'(busy), 0);
    chk("R10 abort hold", int'(hold), 0);
    chk("R10 abort dac", int'(dac), MID);
    chk("R10 abort no done", int'(done), 0);
    chk("R10 amp off", int'(amp_en), 0);
    @(negedge clk) en = 1'b1;
    @(negedge clk);
    chk("R3 warm-up after re-enable", int'(busy), 1);
    dones = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk("R3 rerun warm-up silent", dones, 0);
    chk("R3 result kept", int'(result), 300);
    convert(77, 1'b1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule